// File: doc/BRIEF.md
# Depot Block Store for a Network Interface

This block is a set-associative store that sits in a node's network interface. It holds memory blocks on behalf of other nodes, so that a read request passing through the node can be answered locally instead of travelling on to the block's home node. The interface logic drives two ports. The lookup port takes a block address and returns a hit flag and the block data one cycle later. The message port carries either a fill or an invalidate. A fill is a shared reply from a home node that passes through this node and leaves a copy here. An invalidate is the home node's request to drop a copy.

Every copy in the store is clean and shared. No line is ever dirty, so an evicted line is simply overwritten and nothing is written back. Inclusion with the node's own processor caches is not kept. By default the store holds 16 KB as 4 ways of 32-byte blocks, which gives 128 sets. Within a set, a tree pseudo-LRU picks the line to replace. An empty way is always taken before any valid line is replaced.

Top module: `depot_store`

## Requirements
- R1: After reset, every lookup misses, and `rsp_valid` and `inv_ack` are low until a request is accepted.
- R2: A lookup is accepted when `lk_valid` and `lk_ready` are both high. Exactly one cycle later `rsp_valid` pulses with `rsp_hit`. On a hit, `rsp_data` carries the stored block. On a miss, `rsp_data` is zero. No response appears without an accepted lookup.
- R3: A message with `msg_kind` = 0 (fill) stores `msg_data` under the block address `msg_addr`. A later lookup of that block hits and returns that data.
- R4: A fill of a block that is already stored overwrites that same line. A set never holds two copies of one block.
- R5: A fill that misses places the block in the lowest-numbered invalid way of its set, if any way is invalid.
- R6: When all ways of a set are valid, a missing fill replaces the tree pseudo-LRU victim. Each set keeps WAYS-1 tree bits. Bit 0 at a node steers the victim search to the lower-numbered half of the ways. Every lookup hit and every fill sets the bits on the touched way's path to point away from it. Invalidates leave the bits alone. The replaced line is dropped without any output.
- R7: A message with `msg_kind` = 1 (invalidate) for a stored block clears it. One cycle later `inv_ack` pulses with `inv_found` = 1, and later lookups of that block miss.
- R8: An invalidate for an absent block changes no stored line. It still gives an `inv_ack` pulse one cycle later, with `inv_found` = 0.
- R9: When a fill and a lookup address the same set in one cycle, `lk_ready` is low and the fill is applied first. The held lookup is accepted on a later cycle and sees the filled line.
- R10: A lookup and an invalidate accepted in the same cycle: the lookup returns the contents from before the invalidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup found the block |
| rsp_data | output | BLK_BYTES*8 | Block data (zero on miss) |
| msg_valid | input | 1 | Message present |
| msg_kind | input | 1 | 0 = fill, 1 = invalidate |
| msg_addr | input | ADDR_W | Message byte address |
| msg_data | input | BLK_BYTES*8 | Fill data |
| inv_ack | output | 1 | Invalidate acknowledged |
| inv_found | output | 1 | Invalidated block was present |

## Verification
The hardest state to reach from the ports is a full set whose tree bits point at a particular way, combined with an empty way that must win over that victim. The bench fills a set to capacity in a known order, touches one line with a lookup, and then fills again. It also makes a hole with an invalidate before filling. After each of these steps it looks up every candidate block, which shows which line was dropped. A long pseudo-random sweep over a few tags per set then compares every response against an arithmetic model of the replacement tree. The same-set collision of a fill and a lookup is forced directly by driving both ports in one cycle.

// File: rtl/depot_pkg.sv
package depot_pkg;
  typedef enum logic {
    MSG_FILL = 1'b0,
    MSG_INV  = 1'b1
  } msg_kind_e;
endpackage

// File: rtl/depot_tag_match.sv
module depot_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_row,
  input  logic [TAG_W-1:0] tag_row [WAYS],
  input  logic [TAG_W-1:0] tag_in,
  output logic [WAYS-1:0]  match,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_row[w] && (tag_row[w] == tag_in);
  end

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/depot_plru_bank.sv
module depot_plru_bank #(
  parameter int SETS = 128,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int LG    = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_en,
  input  logic [SET_W-1:0] a_set,
  input  logic [WAY_W-1:0] a_way,
  input  logic             b_en,
  input  logic [SET_W-1:0] b_set,
  input  logic [WAY_W-1:0] b_way,
  input  logic [SET_W-1:0] q_set,
  output logic [WAY_W-1:0] victim
);
  logic [WAYS-2:0] tree_q [SETS];

  // Walk from the root; each bit picks the half holding the victim.
  function automatic logic [WAY_W-1:0] pick(input logic [WAYS-2:0] t);
    int node = 0;
    for (int l = 0; l < LG; l++) node = 2 * node + 1 + int'(t[node]);
    return WAY_W'(node - (WAYS - 1));
  endfunction

  // Point every bit on the path of way w away from it.
  function automatic logic [WAYS-2:0] aim(input logic [WAYS-2:0] t,
                                          input logic [WAY_W-1:0] w);
    logic [WAYS-2:0] r = t;
    int node = 0;
    for (int l = 0; l < LG; l++) begin
      r[node] = ~w[LG-1-l];
      node    = 2 * node + 1 + int'(w[LG-1-l]);
    end
    return r;
  endfunction

  assign victim = pick(tree_q[q_set]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else begin
      if (a_en) tree_q[a_set] <= aim(tree_q[a_set], a_way);
      if (b_en) tree_q[b_set] <= aim(tree_q[b_set], b_way);
    end
  end

  AST_TOUCH_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    !(a_en && b_en && (a_set == b_set))); // R9
endmodule

// File: rtl/depot_store.sv
module depot_store
  import depot_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CAP_BYTES = 16384,
  parameter int BLK_BYTES = 32,
  parameter int WAYS      = 4,
  localparam int DATA_W = BLK_BYTES * 8,
  localparam int SETS   = CAP_BYTES / (BLK_BYTES * WAYS),
  localparam int OFF_W  = $clog2(BLK_BYTES),
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              msg_valid,
  input  logic              msg_kind,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [DATA_W-1:0] msg_data,
  output logic              inv_ack,
  output logic              inv_found
);
  logic [WAYS-1:0]   vld_q [SETS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [DATA_W-1:0] dat_q [SETS][WAYS];

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [WAY_W-1:0] first_free(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (!v[i]) r = WAY_W'(i);
    return r;
  endfunction

  logic             unused_off;
  assign unused_off = ^{lk_addr[OFF_W-1:0], msg_addr[OFF_W-1:0]};

  // Named internal events
  logic [SET_W-1:0] lk_set, ms_set;
  logic [TAG_W-1:0] lk_tag, ms_tag;
  logic             fill_req, inv_req, lk_fire;
  logic [WAYS-1:0]  lk_match, ms_match;
  logic             lk_hit, ms_hit;
  logic [WAY_W-1:0] lk_way, ms_way, victim_way, fill_way;
  msg_kind_e        kind;

  assign kind     = msg_kind_e'(msg_kind);
  assign lk_set   = set_of(lk_addr);
  assign lk_tag   = tag_of(lk_addr);
  assign ms_set   = set_of(msg_addr);
  assign ms_tag   = tag_of(msg_addr);
  assign fill_req = msg_valid && (kind == MSG_FILL);
  assign inv_req  = msg_valid && (kind == MSG_INV);
  assign lk_ready = !(fill_req && (ms_set == lk_set));
  assign lk_fire  = lk_valid && lk_ready;

  depot_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid_row(vld_q[lk_set]), .tag_row(tag_q[lk_set]), .tag_in(lk_tag),
    .match(lk_match), .hit(lk_hit), .hit_way(lk_way)
  );

  depot_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_ms_match (
    .valid_row(vld_q[ms_set]), .tag_row(tag_q[ms_set]), .tag_in(ms_tag),
    .match(ms_match), .hit(ms_hit), .hit_way(ms_way)
  );

  depot_plru_bank #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .rst(rst),
    .a_en(lk_fire && lk_hit), .a_set(lk_set), .a_way(lk_way),
    .b_en(fill_req), .b_set(ms_set), .b_way(fill_way),
    .q_set(ms_set), .victim(victim_way)
  );

  // Refresh in place, else an empty way, else the tree victim.
  always_comb begin
    if (ms_hit)                  fill_way = ms_way;
    else if (~&vld_q[ms_set])    fill_way = first_free(vld_q[ms_set]);
    else                         fill_way = victim_way;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      inv_ack   <= 1'b0;
      inv_found <= 1'b0;
    end else begin
      rsp_valid <= lk_fire;
      rsp_hit   <= lk_fire && lk_hit;
      rsp_data  <= (lk_fire && lk_hit) ? dat_q[lk_set][lk_way] : '0;
      inv_ack   <= inv_req;
      inv_found <= inv_req && ms_hit;
      if (fill_req)           vld_q[ms_set][fill_way] <= 1'b1;
      if (inv_req && ms_hit)  vld_q[ms_set][ms_way]   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_req) begin
      tag_q[ms_set][fill_way] <= ms_tag;
      dat_q[ms_set][fill_way] <= msg_data;
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready) |=> rsp_valid); // R2
  AST_RSP_ONLY_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    !(lk_valid && lk_ready) |=> !rsp_valid); // R2
  AST_FILL_INSTALLS: assert property (@(posedge clk) disable iff (rst)
    fill_req |=> vld_q[$past(ms_set)][$past(fill_way)]); // R3
  AST_ONE_COPY: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ms_match)); // R4
  AST_INV_ACK: assert property (@(posedge clk) disable iff (rst)
    inv_req |=> inv_ack); // R7
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (inv_req && ms_hit) |=> !vld_q[$past(ms_set)][$past(ms_way)]); // R7
  AST_FILL_STALLS: assert property (@(posedge clk) disable iff (rst)
    (fill_req && lk_valid && (ms_set == lk_set)) |=> !rsp_valid); // R9
endmodule

// File: tb/depot_store_tb.sv
module depot_store_tb;
  localparam int AW = 12, CAP = 64, BLK = 4, WAYS = 4;
  localparam int DW = BLK * 8;
  localparam int SETS = CAP / (BLK * WAYS);

  logic clk = 0, rst = 1;
  logic lk_valid = 0, msg_valid = 0, msg_kind = 0;
  logic [AW-1:0] lk_addr = '0, msg_addr = '0;
  logic [DW-1:0] msg_data = '0;
  logic lk_ready, rsp_valid, rsp_hit, inv_ack, inv_found;
  logic [DW-1:0] rsp_data;

  int tests = 0, fails = 0;

  depot_store #(.ADDR_W(AW), .CAP_BYTES(CAP), .BLK_BYTES(BLK), .WAYS(WAYS)) u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_addr(msg_addr), .msg_data(msg_data),
    .inv_ack(inv_ack), .inv_found(inv_found)
  );

  always #2 clk = ~clk;

  // Reference model
  bit        m_v [SETS][WAYS];
  int        m_t [SETS][WAYS];
  logic [DW-1:0] m_d [SETS][WAYS];
  bit [2:0]  m_p [SETS];  // [0] root, [1] ways 0/1, [2] ways 2/3

  function automatic logic [AW-1:0] mk(int tag, int set);
    return AW'((tag * SETS + set) * BLK + (tag % BLK));
  endfunction
  function automatic int set_i(logic [AW-1:0] a); return (int'(a) / BLK) % SETS; endfunction
  function automatic int tag_i(logic [AW-1:0] a); return int'(a) / (BLK * SETS); endfunction

  function automatic void m_touch(int s, int w);
    m_p[s][0] = (w < 2);
    if (w < 2) m_p[s][1] = (w == 0); else m_p[s][2] = (w == 2);
  endfunction
  function automatic int m_victim(int s);
    if (m_p[s][0] == 0) return m_p[s][1] ? 1 : 0;
    return m_p[s][2] ? 3 : 2;
  endfunction
  function automatic int m_find(int s, int t);
    for (int w = 0; w < WAYS; w++) if (m_v[s][w] && m_t[s][w] == t) return w;
    return -1;
  endfunction
  function automatic void m_fill(logic [AW-1:0] a, logic [DW-1:0] d);
    int s = set_i(a), t = tag_i(a), w = m_find(s, t);
    if (w < 0) for (int i = WAYS - 1; i >= 0; i--) if (!m_v[s][i]) w = i;
    if (w < 0) w = m_victim(s);
    m_v[s][w] = 1; m_t[s][w] = t; m_d[s][w] = d;
    m_touch(s, w);
  endfunction

  task automatic check(bit ok, string rq, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic do_lookup(logic [AW-1:0] a, string rq);
    int s = set_i(a), w = m_find(s, tag_i(a));
    logic [DW-1:0] ed;
    lk_valid = 1; lk_addr = a; #1;
    check(lk_ready == 1, rq, DW'(lk_ready), 1);
    tick(); lk_valid = 0;
    ed = (w >= 0) ? m_d[s][w] : '0;
    if (w >= 0) m_touch(s, w);
    check(rsp_valid == 1, rq, DW'(rsp_valid), 1);
    check(rsp_hit == (w >= 0), rq, DW'(rsp_hit), DW'(w >= 0));
    check(rsp_data == ed, rq, rsp_data, ed);
  endtask

  task automatic do_fill(logic [AW-1:0] a, logic [DW-1:0] d);
    msg_valid = 1; msg_kind = 0; msg_addr = a; msg_data = d;
    tick(); msg_valid = 0;
    m_fill(a, d);
  endtask

  task automatic do_inv(logic [AW-1:0] a, string rq);
    int s = set_i(a), w = m_find(s, tag_i(a));
    msg_valid = 1; msg_kind = 1; msg_addr = a;
    tick(); msg_valid = 0;
    check(inv_ack == 1, rq, DW'(inv_ack), 1);
    check(inv_found == (w >= 0), rq, DW'(inv_found), DW'(w >= 0));
    if (w >= 0) m_v[s][w] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [AW-1:0] a;
    for (int s = 0; s < SETS; s++) begin
      m_p[s] = '0;
      for (int w = 0; w < WAYS; w++) m_v[s][w] = 0;
    end
    repeat (3) tick();
    rst = 0;
    // R1: quiet outputs and empty store after reset
    check(rsp_valid == 0, "R1", DW'(rsp_valid), 0);
    check(inv_ack == 0, "R1", DW'(inv_ack), 0);
    for (int s = 0; s < SETS; s++) do_lookup(mk(s + 1, s), "R1");

    // R3: fill then hit
    do_fill(mk(5, 1), 32'hA5A5_0001);
    do_lookup(mk(5, 1), "R3");
    check(m_find(1, 5) >= 0, "R3", 0, 0);

    // R4: refill in place, then three more blocks; all four must stay
    do_fill(mk(5, 1), 32'hBEEF_0002);
    do_fill(mk(6, 1), 32'h0000_0006);
    do_fill(mk(7, 1), 32'h0000_0007);
    do_fill(mk(8, 1), 32'h0000_0008);
    for (int t = 5; t <= 8; t++) do_lookup(mk(t, 1), "R4");

    // R6: full set, touch way 0, next fill evicts tag 12 (way 2)
    for (int t = 10; t < 14; t++) do_fill(mk(t, 2), DW'(32'h2000 + t));
    do_lookup(mk(10, 2), "R6");
    do_fill(mk(14, 2), 32'h2000_000E);
    check(m_find(2, 12) < 0, "R6", 0, 0);
    for (int t = 10; t <= 14; t++) do_lookup(mk(t, 2), "R6");

    // R5: a hole beats the tree victim
    for (int t = 20; t < 24; t++) do_fill(mk(t, 3), DW'(32'h3000 + t));
    do_inv(mk(21, 3), "R7");
    do_fill(mk(29, 3), 32'h3000_001D);
    foreach (m_v[3][w]) check(m_v[3][w] == 1, "R5", 0, 0);
    do_lookup(mk(20, 3), "R5");
    do_lookup(mk(29, 3), "R5");
    do_lookup(mk(21, 3), "R7");

    // R8: absent invalidate changes nothing
    do_inv(mk(30, 3), "R8");
    for (int t = 22; t < 24; t++) do_lookup(mk(t, 3), "R8");

    // R9: same-set fill holds the lookup off
    msg_valid = 1; msg_kind = 0; msg_addr = mk(40, 0); msg_data = 32'h9999_0000;
    lk_valid = 1; lk_addr = mk(40, 0); #1;
    check(lk_ready == 0, "R9", DW'(lk_ready), 0);
    tick();
    check(rsp_valid == 0, "R9", DW'(rsp_valid), 0);
    msg_valid = 0; m_fill(mk(40, 0), 32'h9999_0000); #1;
    check(lk_ready == 1, "R9", DW'(lk_ready), 1);
    tick(); lk_valid = 0;
    check(rsp_valid == 1 && rsp_hit == 1, "R9", DW'({rsp_valid, rsp_hit}), 3);
    check(rsp_data == 32'h9999_0000, "R9", rsp_data, 32'h9999_0000);
    m_touch(0, m_find(0, 40));

    // R10: lookup sees contents from before a same-cycle invalidate
    msg_valid = 1; msg_kind = 1; msg_addr = mk(40, 0);
    lk_valid = 1; lk_addr = mk(40, 0);
    tick(); msg_valid = 0; lk_valid = 0;
    check(rsp_hit == 1 && rsp_data == 32'h9999_0000, "R10", rsp_data, 32'h9999_0000);
    check(inv_ack == 1 && inv_found == 1, "R10", DW'({inv_ack, inv_found}), 3);
    m_v[0][m_find(0, 40)] = 0;
    do_lookup(mk(40, 0), "R7");

    // Sweep: pseudo-random ops over few tags per set, all sets
    r = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      r = r * 32'd1664525 + 32'd1013904223;
      a = mk(int'(r[15:12]) % 6, int'(r[19:18]));
      case (r[25:24])
        2'd0, 2'd1: do_lookup(a, "R6");
        2'd2:       do_fill(a, r ^ 32'h5A5A_A5A5);
        default:    do_inv(a, "R7");
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule